// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Frame Controller

This block sits behind a memory-mapped window and turns byte-wide system bus reads and writes into instruction frames for a serial flash. The first access to arrive opens a frame. The frame carries an opcode byte, chosen by the access direction, and then the access address sent most significant byte first. A read frame adds a programmable number of dummy bytes, and then the data bytes follow. While a frame is open, an access to the next consecutive address in the same direction only adds one data byte. An access to any other address, or in the other direction, closes the frame. A new frame then opens at the address of that access. A close request input ends an open frame on demand.

Bytes pass to a byte-level shifter through a valid/ready handshake. The shifter reports read busy and link idle status, and a frame may end only when reads are not busy and the link is idle. A write-byte counter raises a one-cycle pulse when a programmed byte count is reached. A separate pulse marks the end of each write frame. In normal operation the counter restarts at every frame start. In write-buffer mode (protocol select 3 with the buffer enable set) the counter restarts when that mode becomes active, and it then counts across frames.

States: IDLE (no frame), CMD (opcode byte), ADDR (address bytes), DUMMY (read dummy bytes), DATA (one data byte), HOLD (frame open, waiting for the next access), CLOSE (waiting for the link to settle). Transitions: IDLE→CMD when an access is pending. CMD→ADDR when the opcode byte is taken. ADDR→DUMMY after the last address byte of a read with a non-zero dummy count, otherwise ADDR→DATA. DUMMY→DATA after the last dummy byte. DATA→HOLD when the data byte is taken. HOLD→CLOSE on a close request or on a non-consecutive access. HOLD→DATA on a consecutive access. CLOSE→IDLE once the link is idle and not read-busy.

Top module: `mmf_frame_ctrl`

## Requirements
- R1: A pending access in an idle controller opens a frame. The frame starts with one CMD byte (`sh_kind`=0), which is `cfg_rd_opcode` for a read or `cfg_wr_opcode` for a write. ADDR bytes (`sh_kind`=1) follow, AW/8 of them, carrying the access address most significant byte first.
- R2: After its address, a read frame sends `cfg_dummy` DUMMY bytes (`sh_kind`=2) and then one DATA byte (`sh_kind`=3). `bus_ready` stays low until that data byte is handshaken. In that cycle `bus_rdata` equals `sh_rdata`.
- R3: An access whose address is the previous address plus one (modulo 2^AW), in the same direction, continues the open frame. It adds exactly one DATA byte and no new CMD or ADDR bytes.
- R4: An access with any other address, or in the other direction, closes the open frame. It then opens a new frame whose address field is that access's address.
- R5: A `close_req` pulse while a frame waits for the next access closes the frame. If an access arrives in the same cycle, even a consecutive one, the close wins and the access opens a new frame.
- R6: A frame stays open (`frame_active`=1) until `phy_rd_busy`=0 and `phy_idle`=1 hold together. Only then does it close.
- R7: `wr_thresh_hit` pulses for one cycle. The pulse comes in the cycle after the handshake of the write data byte that brings the write-byte count equal to `cfg_wr_thresh`.
- R8: When write-buffer mode is off, the write-byte count returns to zero at the start of every frame.
- R9: Write-buffer mode is active when `cfg_proto`=3 and `cfg_wbuf_en`=1. When this mode becomes active the count returns to zero. While it stays active, frame starts do not clear the count.
- R10: `wr_last_hit` pulses for one cycle, in the first cycle that `frame_active` is low after a write frame closes. It never pulses after a read frame.
- R11: After reset, `frame_active`, `sh_valid`, `bus_ready`, `wr_thresh_hit` and `wr_last_hit` are all 0.
- R12: Each write DATA byte carries the `bus_wdata` of its access. The access's `bus_ready` rises in the cycle in which the shifter takes the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rd_opcode | input | 8 | Opcode byte for read frames |
| cfg_wr_opcode | input | 8 | Opcode byte for write frames |
| cfg_dummy | input | DUMMY_W | Dummy byte count for read frames |
| cfg_wr_thresh | input | CW | Write-byte count that raises the threshold pulse |
| cfg_proto | input | 2 | Protocol select; value 3 allows write-buffer mode |
| cfg_wbuf_en | input | 1 | Write-buffer enable |
| bus_valid | input | 1 | Bus access request, held until bus_ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address inside the window |
| bus_wdata | input | 8 | Write data |
| bus_ready | output | 1 | Access completes this cycle |
| bus_rdata | output | 8 | Read data, valid with bus_ready |
| close_req | input | 1 | Request to end the open frame |
| sh_valid | output | 1 | Byte offered to the shifter |
| sh_kind | output | 2 | Byte kind: 0 CMD, 1 ADDR, 2 DUMMY, 3 DATA |
| sh_data | output | 8 | Byte to shift out |
| sh_ready | input | 1 | Shifter takes the byte |
| sh_rdata | input | 8 | Byte shifted in during a read DATA byte |
| phy_rd_busy | input | 1 | Shifter still busy with read data |
| phy_idle | input | 1 | Serial link idle |
| frame_active | output | 1 | A frame is open |
| wr_thresh_hit | output | 1 | Write-byte threshold pulse |
| wr_last_hit | output | 1 | Last write byte sent; frame closed |

## Verification
The main overlap is a close request that lands in the same cycle as a consecutive access. Either event alone leads the frame to a different place: the request ends the frame, and the access would extend it. The bench drives both on the same clock edge while the frame waits for the next access. It then expects two frame openings, the second one carrying the address of the access. The monitor checks the decoded address bytes against that expectation. In random traffic, closes are also mixed with bursts, jumps and stalls of the shifter's ready signal, so counter pulses and frame-end pulses fall near frame boundaries.

// File: rtl/mmf_pkg.sv
package mmf_pkg;

    typedef enum logic [1:0] {
        KIND_CMD   = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_DUMMY = 2'd2,
        KIND_DATA  = 2'd3
    } mmf_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_HOLD,
        ST_CLOSE
    } mmf_state_e;

endpackage

// File: rtl/mmf_seq_track.sv
module mmf_seq_track #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_open,
    input  logic          data_fire,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_write,
    output logic          seq_hit,
    output logic          frame_wr,
    output logic [AW-1:0] frame_addr
);

    logic [AW-1:0] next_addr;

    // Base address and direction are captured when a frame opens; the
    // expected next address advances by one byte per accepted data byte.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_addr <= '0;
            frame_wr   <= 1'b0;
            next_addr  <= '0;
        end else if (frame_open) begin
            frame_addr <= bus_addr;
            frame_wr   <= bus_write;
            next_addr  <= bus_addr;
        end else if (data_fire) begin
            next_addr  <= next_addr + AW'(1);
        end
    end

    assign seq_hit = (bus_addr == next_addr) && (bus_write == frame_wr);

endmodule

// File: rtl/mmf_wr_counter.sv
module mmf_wr_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wbuf_mode,
    input  logic          frame_open,
    input  logic          byte_fire,
    input  logic [CW-1:0] thresh,
    output logic          hit
);

    logic          wbuf_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc = cnt + CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbuf_q <= 1'b0;
            cnt    <= '0;
            hit    <= 1'b0;
        end else begin
            wbuf_q <= wbuf_mode;
            hit    <= 1'b0;
            if (wbuf_mode && !wbuf_q) begin
                cnt <= '0;
            end else if (frame_open && !wbuf_mode) begin
                cnt <= '0;
            end else if (byte_fire) begin
                cnt <= cnt_inc;
                hit <= (cnt_inc == thresh);
            end
        end
    end

endmodule

// File: rtl/mmf_frame_fsm.sv
module mmf_frame_fsm
    import mmf_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DUMMY_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               close_req,
    input  logic               seq_hit,
    input  logic               frame_wr,
    input  logic [AW-1:0]      frame_addr,
    input  logic [7:0]         cfg_rd_opcode,
    input  logic [7:0]         cfg_wr_opcode,
    input  logic [DUMMY_W-1:0] cfg_dummy,
    input  logic [7:0]         bus_wdata,
    input  logic               sh_ready,
    input  logic [7:0]         sh_rdata,
    input  logic               phy_rd_busy,
    input  logic               phy_idle,
    output logic               frame_open,
    output logic               data_fire,
    output logic               sh_valid,
    output mmf_kind_e          sh_kind,
    output logic [7:0]         sh_data,
    output logic               bus_ready,
    output logic [7:0]         bus_rdata,
    output logic               frame_active,
    output logic               wr_last_hit
);

    localparam int ABW   = AW / 8;
    localparam int ABW_W = (ABW > 1) ? $clog2(ABW) : 1;
    localparam int IDX_W = ((DUMMY_W > ABW_W) ? DUMMY_W : ABW_W) + 1;

    mmf_state_e     state;
    mmf_state_e     state_nx;
    logic [IDX_W-1:0] idx;
    logic           sh_fire;
    logic           addr_last;
    logic           dummy_last;
    logic           link_quiet;
    logic [AW-1:0]  addr_sh;

    assign sh_fire    = sh_valid && sh_ready;
    assign addr_last  = (idx == IDX_W'(ABW - 1));
    assign dummy_last = (idx == (IDX_W'(cfg_dummy) - IDX_W'(1)));
    assign link_quiet = !phy_rd_busy && phy_idle;
    assign addr_sh    = frame_addr >> ((ABW - 1 - int'(idx)) * 8);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (bus_valid) state_nx = ST_CMD;
            ST_CMD:   if (sh_fire) state_nx = ST_ADDR;
            ST_ADDR:  if (sh_fire && addr_last)
                          state_nx = (!frame_wr && cfg_dummy != '0) ? ST_DUMMY : ST_DATA;
            ST_DUMMY: if (sh_fire && dummy_last) state_nx = ST_DATA;
            ST_DATA:  if (sh_fire) state_nx = ST_HOLD;
            ST_HOLD: begin
                if (close_req)      state_nx = ST_CLOSE;
                else if (bus_valid) state_nx = seq_hit ? ST_DATA : ST_CLOSE;
            end
            ST_CLOSE: if (link_quiet) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register with its byte index and the frame-end pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            idx         <= '0;
            wr_last_hit <= 1'b0;
        end else begin
            state       <= state_nx;
            wr_last_hit <= (state == ST_CLOSE) && link_quiet && frame_wr;
            if (state_nx != state) idx <= '0;
            else if (sh_fire)      idx <= idx + IDX_W'(1);
        end
    end

    always_comb begin
        sh_valid     = 1'b0;
        sh_kind      = KIND_CMD;
        sh_data      = '0;
        bus_ready    = 1'b0;
        bus_rdata    = '0;
        frame_open   = 1'b0;
        data_fire    = 1'b0;
        frame_active = (state != ST_IDLE);
        unique case (state)
            ST_IDLE: frame_open = bus_valid;
            ST_CMD: begin
                sh_valid = 1'b1;
                sh_data  = frame_wr ? cfg_wr_opcode : cfg_rd_opcode;
            end
            ST_ADDR: begin
                sh_valid = 1'b1;
                sh_kind  = KIND_ADDR;
                sh_data  = addr_sh[7:0];
            end
            ST_DUMMY: begin
                sh_valid = 1'b1;
                sh_kind  = KIND_DUMMY;
            end
            ST_DATA: begin
                sh_valid  = bus_valid;
                sh_kind   = KIND_DATA;
                sh_data   = frame_wr ? bus_wdata : 8'h00;
                bus_ready = bus_valid && sh_ready;
                bus_rdata = frame_wr ? 8'h00 : sh_rdata;
                data_fire = bus_valid && sh_ready;
            end
            ST_HOLD:  ;
            ST_CLOSE: ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/mmf_frame_ctrl.sv
module mmf_frame_ctrl
    import mmf_pkg::*;
#(
    parameter int AW      = 16,
    parameter int CW      = 8,
    parameter int DUMMY_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         cfg_rd_opcode,
    input  logic [7:0]         cfg_wr_opcode,
    input  logic [DUMMY_W-1:0] cfg_dummy,
    input  logic [CW-1:0]      cfg_wr_thresh,
    input  logic [1:0]         cfg_proto,
    input  logic               cfg_wbuf_en,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [AW-1:0]      bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic               bus_ready,
    output logic [7:0]         bus_rdata,
    input  logic               close_req,
    output logic               sh_valid,
    output logic [1:0]         sh_kind,
    output logic [7:0]         sh_data,
    input  logic               sh_ready,
    input  logic [7:0]         sh_rdata,
    input  logic               phy_rd_busy,
    input  logic               phy_idle,
    output logic               frame_active,
    output logic               wr_thresh_hit,
    output logic               wr_last_hit
);

    logic          frame_open;
    logic          data_fire;
    logic          seq_hit;
    logic          frame_wr;
    logic [AW-1:0] frame_addr;
    logic          wbuf_mode;
    mmf_kind_e     kind;

    assign wbuf_mode = (cfg_proto == 2'd3) && cfg_wbuf_en;
    assign sh_kind   = kind;

    mmf_seq_track #(.AW(AW)) i_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_open (frame_open),
        .data_fire  (data_fire),
        .bus_addr   (bus_addr),
        .bus_write  (bus_write),
        .seq_hit    (seq_hit),
        .frame_wr   (frame_wr),
        .frame_addr (frame_addr)
    );

    mmf_frame_fsm #(.AW(AW), .DUMMY_W(DUMMY_W)) i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_valid     (bus_valid),
        .close_req     (close_req),
        .seq_hit       (seq_hit),
        .frame_wr      (frame_wr),
        .frame_addr    (frame_addr),
        .cfg_rd_opcode (cfg_rd_opcode),
        .cfg_wr_opcode (cfg_wr_opcode),
        .cfg_dummy     (cfg_dummy),
        .bus_wdata     (bus_wdata),
        .sh_ready      (sh_ready),
        .sh_rdata      (sh_rdata),
        .phy_rd_busy   (phy_rd_busy),
        .phy_idle      (phy_idle),
        .frame_open    (frame_open),
        .data_fire     (data_fire),
        .sh_valid      (sh_valid),
        .sh_kind       (kind),
        .sh_data       (sh_data),
        .bus_ready     (bus_ready),
        .bus_rdata     (bus_rdata),
        .frame_active  (frame_active),
        .wr_last_hit   (wr_last_hit)
    );

    mmf_wr_counter #(.CW(CW)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .wbuf_mode  (wbuf_mode),
        .frame_open (frame_open),
        .byte_fire  (data_fire && frame_wr),
        .thresh     (cfg_wr_thresh),
        .hit        (wr_thresh_hit)
    );

endmodule

// File: rtl/mmf_frame_ctrl_chk.sv
module mmf_frame_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sh_valid,
    input logic       sh_ready,
    input logic [1:0] sh_kind,
    input logic [7:0] sh_data,
    input logic       bus_ready,
    input logic       frame_active,
    input logic       phy_rd_busy,
    input logic       wr_thresh_hit,
    input logic       wr_last_hit
);

    // R1
    start_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_active) |-> (sh_valid && sh_kind == 2'd0));

    // R1
    offer_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_valid && !sh_ready) |=> (sh_valid && $stable(sh_kind) && $stable(sh_data)));

    // R2
    ready_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> (sh_valid && sh_ready && sh_kind == 2'd3));

    // R6
    busy_keeps_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && phy_rd_busy) |=> frame_active);

    // R7
    thresh_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_thresh_hit |=> !wr_thresh_hit);

    // R10
    last_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_last_hit |-> (!frame_active && $past(frame_active)));

endmodule

bind mmf_frame_ctrl mmf_frame_ctrl_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sh_valid      (sh_valid),
    .sh_ready      (sh_ready),
    .sh_kind       (sh_kind),
    .sh_data       (sh_data),
    .bus_ready     (bus_ready),
    .frame_active  (frame_active),
    .phy_rd_busy   (phy_rd_busy),
    .wr_thresh_hit (wr_thresh_hit),
    .wr_last_hit   (wr_last_hit)
);

// File: tb/test_mmf_frame_ctrl.sv
`timescale 1ns/1ps
module test_mmf_frame_ctrl;

    localparam int AW = 16;
    localparam int CW = 8;
    localparam int DUMMY_W = 3;
    localparam int ABW = AW / 8;
    localparam logic [7:0] RD_OP = 8'h0B;
    localparam logic [7:0] WR_OP = 8'h02;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DUMMY_W-1:0] cfg_dummy = 3'd2;
    logic [CW-1:0] cfg_wr_thresh = 8'd3;
    logic [1:0] cfg_proto = 2'd0;
    logic cfg_wbuf_en = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic bus_ready;
    logic [7:0] bus_rdata;
    logic close_req = 1'b0;
    logic sh_valid;
    logic [1:0] sh_kind;
    logic [7:0] sh_data;
    logic sh_ready = 1'b1;
    logic [7:0] sh_rdata;
    logic phy_rd_busy = 1'b0, phy_idle = 1'b1;
    logic frame_active, wr_thresh_hit, wr_last_hit;

    int n_checks = 0, n_err = 0;
    bit done = 0, rnd_ready = 0;

    // expected frames and write bytes
    logic [AW-1:0] ef_addr [0:1023];
    logic          ef_wr   [0:1023];
    int ef_n = 0;
    logic [7:0] ewd [0:2047];
    int ewd_n = 0;
    bit exp_open = 0, exp_wr = 0;
    logic [AW-1:0] exp_next = '0;

    // monitor state
    int fidx = 0, wdi = 0, mon_ab = 0, mon_dum = 0, mon_k = 0, thr_seen = 0;
    logic [AW-1:0] mon_addr = '0;
    logic [CW-1:0] mcnt = '0;
    bit mon_wr = 0, mon_wb_prev = 0, exp_thr = 0, prev_fa = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    assign sh_rdata = mem_byte(mon_addr + AW'(mon_k));

    mmf_frame_ctrl #(.AW(AW), .CW(CW), .DUMMY_W(DUMMY_W)) i_mmf_frame_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_rd_opcode(RD_OP), .cfg_wr_opcode(WR_OP), .cfg_dummy(cfg_dummy),
        .cfg_wr_thresh(cfg_wr_thresh), .cfg_proto(cfg_proto), .cfg_wbuf_en(cfg_wbuf_en),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .close_req(close_req), .sh_valid(sh_valid), .sh_kind(sh_kind),
        .sh_data(sh_data), .sh_ready(sh_ready), .sh_rdata(sh_rdata),
        .phy_rd_busy(phy_rd_busy), .phy_idle(phy_idle), .frame_active(frame_active),
        .wr_thresh_hit(wr_thresh_hit), .wr_last_hit(wr_last_hit)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // shifter ready, driven just after the rising edge
    always begin
        @(posedge clk);
        #1;
        sh_ready = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
    end

    // monitor: samples after the falling edge
    always begin
        @(negedge clk);
        #3;
        if (rst_n) begin
            if (exp_thr || wr_thresh_hit)
                check(wr_thresh_hit == exp_thr, "R7", {31'd0, wr_thresh_hit}, {31'd0, exp_thr});
            if (wr_thresh_hit) thr_seen++;
            if (prev_fa && !frame_active)
                check(wr_last_hit == mon_wr, "R10", {31'd0, wr_last_hit}, {31'd0, mon_wr});
            else if (wr_last_hit)
                check(1'b0, "R10", 32'd1, 32'd0);
            if ((cfg_proto == 2'd3 && cfg_wbuf_en) && !mon_wb_prev) mcnt = '0;
            mon_wb_prev = (cfg_proto == 2'd3 && cfg_wbuf_en);
            exp_thr = 0;
            if (sh_valid && sh_ready) begin
                case (sh_kind)
                    2'd0: begin
                        mon_wr = ef_wr[fidx];
                        check(sh_data == (mon_wr ? WR_OP : RD_OP), "R1",
                              {24'd0, sh_data}, {24'd0, (mon_wr ? WR_OP : RD_OP)});
                        mon_ab = 0; mon_dum = 0; mon_k = 0; mon_addr = '0;
                        if (!mon_wb_prev) mcnt = '0;
                    end
                    2'd1: begin
                        mon_addr = {mon_addr[AW-9:0], sh_data};
                        mon_ab++;
                        if (mon_ab == ABW) begin
                            check(mon_addr == ef_addr[fidx], "R4", {16'd0, mon_addr}, {16'd0, ef_addr[fidx]});
                            fidx++;
                        end
                    end
                    2'd2: mon_dum++;
                    default: begin
                        if (mon_k == 0)
                            check(mon_dum == (mon_wr ? 0 : int'(cfg_dummy)), "R2",
                                  mon_dum, (mon_wr ? 0 : int'(cfg_dummy)));
                        if (mon_wr) begin
                            check(sh_data == ewd[wdi], "R12", {24'd0, sh_data}, {24'd0, ewd[wdi]});
                            wdi++;
                            mcnt = mcnt + CW'(1);
                            if (mcnt == cfg_wr_thresh) exp_thr = 1;
                        end
                        mon_k++;
                    end
                endcase
            end
            prev_fa = frame_active;
        end
    end

    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [7:0] d, input bit with_close);
        int waited = 0;
        bit newf;
        if (with_close) exp_open = 0;
        newf = !exp_open || a != exp_next || wr != exp_wr;
        if (newf) begin
            ef_addr[ef_n] = a; ef_wr[ef_n] = wr; ef_n++;
        end
        exp_open = 1; exp_next = a + AW'(1); exp_wr = wr;
        if (wr) begin ewd[ewd_n] = d; ewd_n++; end
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        close_req = with_close;
        if (with_close) begin
            @(posedge clk); #1;
            close_req = 1'b0;
        end
        forever begin
            @(negedge clk);
            if (bus_ready) break;
            waited++;
        end
        if (!wr) begin
            check(bus_rdata == mem_byte(a), "R2", {24'd0, bus_rdata}, {24'd0, mem_byte(a)});
            if (newf && !with_close)
                check(waited >= 1 + ABW + int'(cfg_dummy), "R2", waited, 1 + ABW + int'(cfg_dummy));
        end
    endtask

    task automatic close_frame();
        @(posedge clk); #1;
        bus_valid = 1'b0; close_req = 1'b1;
        @(posedge clk); #1;
        close_req = 1'b0;
        exp_open = 0;
        while (frame_active) @(negedge clk);
    endtask

    task automatic idle(input int n);
        @(posedge clk); #1;
        bus_valid = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    initial begin
        int t0, f0;
        logic [AW-1:0] ra;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11
        check(!frame_active && !sh_valid && !bus_ready && !wr_thresh_hit && !wr_last_hit,
              "R11", {27'd0, frame_active, sh_valid, bus_ready, wr_thresh_hit, wr_last_hit}, 32'd0);

        // R3 / R7: one write burst of four bytes, threshold 3
        t0 = thr_seen; f0 = ef_n;
        for (int i = 0; i < 4; i++) access(1, 16'h1000 + 16'(i), 8'h30 + 8'(i), 0);
        close_frame();
        check(thr_seen - t0 == 1, "R7", thr_seen - t0, 1);
        check(fidx - f0 == 1, "R3", fidx - f0, 1);

        // R8: two 2-byte frames in normal mode never reach 3
        t0 = thr_seen;
        access(1, 16'h2000, 8'h11, 0); access(1, 16'h2001, 8'h12, 0); close_frame();
        access(1, 16'h2100, 8'h13, 0); access(1, 16'h2101, 8'h14, 0); close_frame();
        check(thr_seen - t0 == 0, "R8", thr_seen - t0, 0);

        // R9: write-buffer mode counts across frames, threshold 5
        cfg_proto = 2'd3; cfg_wbuf_en = 1'b1; cfg_wr_thresh = 8'd5;
        idle(2);
        t0 = thr_seen;
        for (int f = 0; f < 3; f++) begin
            access(1, 16'h2200 + 16'(f * 16), 8'h40, 0);
            access(1, 16'h2201 + 16'(f * 16), 8'h41, 0);
            close_frame();
        end
        check(thr_seen - t0 == 1, "R9", thr_seen - t0, 1);
        cfg_wbuf_en = 1'b0; cfg_proto = 2'd0; cfg_wr_thresh = 8'd3;
        idle(2);

        // R4: read burst, address jump, direction flip
        f0 = fidx;
        access(0, 16'h3000, 8'h00, 0); access(0, 16'h3001, 8'h00, 0);
        access(0, 16'h3100, 8'h00, 0);
        access(1, 16'h3101, 8'h77, 0);
        close_frame();
        check(fidx - f0 == 3, "R4", fidx - f0, 3);

        // R5: close and consecutive access in the same cycle
        f0 = fidx;
        access(1, 16'h4000, 8'h51, 0);
        access(1, 16'h4001, 8'h52, 1);
        close_frame();
        check(fidx - f0 == 2, "R5", fidx - f0, 2);

        // R6: frame held open while read busy or link not idle
        access(0, 16'h5000, 8'h00, 0);
        @(posedge clk); #1;
        bus_valid = 1'b0; phy_rd_busy = 1'b1; close_req = 1'b1;
        @(posedge clk); #1;
        close_req = 1'b0;
        repeat (4) @(negedge clk);
        check(frame_active == 1'b1, "R6", {31'd0, frame_active}, 32'd1);
        @(posedge clk); #1;
        phy_rd_busy = 1'b0; phy_idle = 1'b0;
        repeat (3) @(negedge clk);
        check(frame_active == 1'b1, "R6", {31'd0, frame_active}, 32'd1);
        @(posedge clk); #1;
        phy_idle = 1'b1;
        repeat (2) @(negedge clk);
        check(frame_active == 1'b0, "R6", {31'd0, frame_active}, 32'd0);
        exp_open = 0;

        // random traffic
        rnd_ready = 1; cfg_dummy = 3'd1;
        ra = 16'h6000;
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 5 && exp_open) begin
                ra = exp_next;
                access(exp_wr, ra, 8'($urandom), 0);
            end else if (r < 7) begin
                ra = 16'($urandom);
                access(exp_open ? exp_wr : 1'b1, ra, 8'($urandom), 0);
            end else if (r < 8) begin
                ra = 16'($urandom);
                access(!exp_wr, ra, 8'($urandom), (($urandom % 3) == 0) && exp_open);
            end else if (r == 8 && exp_open) begin
                close_frame();
            end else begin
                idle(int'($urandom % 3));
            end
        end
        close_frame();
        rnd_ready = 0;
        idle(3);
        check(fidx == ef_n, "R3", fidx, ef_n);
        check(wdi == ewd_n, "R12", wdi, ewd_n);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_err++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

endmodule